// File: doc/BRIEF.md
# Banked Host Packet Buffer with Data-Request Interrupt

This block sits between a host processor and the audio consumers of a sound engine. The host pushes byte packets for one song stream and for up to two wave streams, each stream through its own write strobe on a shared byte bus. Every stream owns two banks that are used in ping-pong fashion. The host fills one bank while the consumer drains the other. The consumer side reads bytes in order through one read port per stream.

A drained bank is reported to the host through an active-low interrupt and a read-only request register. The request register also carries a song-finished flag and a sticky overflow flag. Reading the register hands back every flag that is set and clears those flags. Any flag that arrives in the same cycle as the read stays pending. The song bank is sealed by a non-zero end-of-packet write. A wave bank seals itself when its packet length is reached, and that length follows the configured wave channel count. The wave storage is one shared array of four half-packet banks. With a single wave channel, the first wave stream takes the array as two full-size banks.

Top module: `stream_pkt_buffer`

## Requirements
- R1: After reset, `irq_n` is 1, `req_data` is 0x00 and all three read-valid outputs are 0.
- R2: Song bytes come out of `song_rd_data` in the order they were written. A song bank is sealed only by `song_eop` with a non-zero `host_wdata`. A zero value leaves the bank open and `song_rd_valid` at 0.
- R3: A write is dropped when it would go past the stream's packet length or into a bank that is still full. The drop sets bit 3 of the request register. Bit 3 never drives `irq_n` low.
- R4: With `wave_chan` = 1, a wave-1 bank holds 128 bytes and seals itself on the 128th byte. Wave-2 writes are ignored: `wave2_rd_valid` stays 0 and no overflow is flagged.
- R5: With `wave_chan` = 2, each wave stream seals a bank after exactly 64 bytes. The 63rd byte does not seal it.
- R6: With `wave_chan` = 0 (or 3), both wave streams are inactive. Their writes are ignored and their read-valid outputs stay 0.
- R7: A request flag is set when the consumer reads the last byte of a bank while the stream's other bank is full. The flags are bit 2 for the song stream, bit 1 for wave 1 and bit 0 for wave 2. The flag and `irq_n` = 0 appear at the clock edge that takes that read. No flag is raised if the other bank is empty.
- R8: `req_data` shows the flags in the cycle `req_rd` is high. The flags shown are cleared at that edge, and `irq_n` returns to 1 at that edge when no new event arrives.
- R9: An event that arrives in the same cycle as `req_rd` is not cleared. It is visible after that edge and keeps `irq_n` at 0.
- R10: A `song_end` pulse sets bit 5 and drives `irq_n` to 0.
- R11: A change of `wave_chan` discards the contents of both wave streams within one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_wdata | input | 8 | Host byte bus shared by all write strobes |
| song_wr | input | 1 | Write one song byte |
| song_eop | input | 1 | Seal the song packet when host_wdata is non-zero |
| wave1_wr | input | 1 | Write one wave-1 byte |
| wave2_wr | input | 1 | Write one wave-2 byte |
| wave_chan | input | 2 | Active wave channel count: 0, 1 or 2 |
| song_rd | input | 1 | Consumer takes one song byte |
| song_rd_valid | output | 1 | A sealed song bank is available |
| song_rd_data | output | 8 | Current song byte |
| wave1_rd | input | 1 | Consumer takes one wave-1 byte |
| wave1_rd_valid | output | 1 | A sealed wave-1 bank is available |
| wave1_rd_data | output | 8 | Current wave-1 byte |
| wave2_rd | input | 1 | Consumer takes one wave-2 byte |
| wave2_rd_valid | output | 1 | A sealed wave-2 bank is available |
| wave2_rd_data | output | 8 | Current wave-2 byte |
| song_end | input | 1 | Song playback finished event |
| req_rd | input | 1 | Host read of the request register |
| req_data | output | 8 | Request flags: 0 wave 2, 1 wave 1, 2 song, 3 overflow, 5 song end |
| irq_n | output | 1 | Data-request interrupt, active low |

## Verification
Writes, seals, flag updates and the interrupt all take effect at the rising edge that samples the strobe. A sealed bank's valid flag, a new request flag or a dropped byte's overflow bit can therefore be read at the next falling edge. `req_data` and the read data are combinational. They are sampled 1 ns after the strobes are driven on the falling edge, inside the same cycle. The bench changes inputs only on falling edges. It waits two falling edges after every `wave_chan` change, which lets the flush edge pass before any wave traffic.

// File: rtl/pkt_pkg.sv
// Shared constants for the banked packet buffer: stream indices, request
// register bit positions and the wave channel count codes.
package pkt_pkg;
    localparam int N_STREAMS = 3;
    localparam int ST_SONG   = 0;
    localparam int ST_WAVE1  = 1;
    localparam int ST_WAVE2  = 2;

    // Request register bit positions seen by the host.
    localparam int RQ_WAVE2 = 0;
    localparam int RQ_WAVE1 = 1;
    localparam int RQ_SONG  = 2;
    localparam int RQ_OVF   = 3;
    localparam int RQ_END   = 5;

    // Flags that pull the interrupt low (overflow is status only).
    localparam logic [7:0] IRQ_MASK = 8'b0010_0111;

    typedef enum logic [1:0] {
        WCH_NONE = 2'd0,
        WCH_ONE  = 2'd1,
        WCH_TWO  = 2'd2,
        WCH_RSVD = 2'd3
    } wave_cfg_e;
endpackage

// File: rtl/pkt_bank_ctrl.sv
// Ping-pong bank controller for one stream. It keeps the fill and drain
// pointers for two banks and seals a bank either on an explicit close or
// automatically at the packet length. It flags a refill request when a bank
// drains while the other bank is full.
// Assumes: pkt_len is 1..PKT_BYTES and stays constant between clears.
module pkt_bank_ctrl #(
    parameter int PKT_BYTES = 128,
    parameter int CW        = $clog2(PKT_BYTES + 1),
    parameter int IW        = $clog2(PKT_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] pkt_len,
    input  logic          auto_close,
    input  logic          wr,
    input  logic          close,
    input  logic          rd,
    output logic          wr_ok,
    output logic          wr_bank,
    output logic [IW-1:0] wr_idx,
    output logic          drop,
    output logic          rd_valid,
    output logic          rd_bank,
    output logic [IW-1:0] rd_idx,
    output logic          drain_req
);
    logic          wb, rb;
    logic [1:0]    full;
    logic [CW-1:0] wcnt, rcnt;
    logic [CW-1:0] blen [2];
    logic [CW-1:0] wcnt_nx;
    logic          seal, rd_take, last;

    // Write acceptance, sealing and drain detection for the current cycle.
    always_comb begin
        wr_ok     = wr & ~clear & ~full[wb] & (wcnt < pkt_len);
        drop      = wr & ~clear & ~wr_ok;
        wcnt_nx   = CW'(wcnt + CW'(wr_ok));
        seal      = (auto_close & wr_ok & (wcnt_nx == pkt_len)) |
                    (~auto_close & close & ~clear & ~full[wb] & (wcnt_nx != '0));
        rd_take   = rd & ~clear & full[rb];
        last      = rd_take & (CW'(rcnt + 1'b1) == blen[rb]);
        drain_req = last & full[~rb];
    end

    // Bank state: fill pointer, drain pointer, full bits and sealed lengths.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wb   <= 1'b0;
            rb   <= 1'b0;
            full <= '0;
            wcnt <= '0;
            rcnt <= '0;
            for (int b = 0; b < 2; b++) blen[b] <= '0;
        end else begin
            if (seal) begin
                full[wb] <= 1'b1;
                blen[wb] <= wcnt_nx;
                wb       <= ~wb;
                wcnt     <= '0;
            end else begin
                wcnt <= wcnt_nx;
            end
            if (rd_take) begin
                if (last) begin
                    full[rb] <= 1'b0;
                    rb       <= ~rb;
                    rcnt     <= '0;
                end else begin
                    rcnt <= CW'(rcnt + 1'b1);
                end
            end
        end
    end

    assign wr_bank  = wb;
    assign wr_idx   = wcnt[IW-1:0];
    assign rd_valid = full[rb];
    assign rd_bank  = rb;
    assign rd_idx   = rcnt[IW-1:0];
endmodule

// File: rtl/pkt_req_reg.sv
// Request register with interrupt. Events set flags. A host read returns the
// current flags and clears exactly those, while events that arrive in the
// same cycle stay pending. The interrupt is registered from the next flags.
module pkt_req_reg
    import pkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] set_evt,
    input  logic       rd,
    output logic [7:0] flags,
    output logic       irq_n
);
    logic [7:0] flags_nx;

    // Next flag value: snapshot cleared on read, new events always merged.
    always_comb flags_nx = (rd ? 8'h00 : flags) | set_evt;

    // Flag and interrupt registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= 8'h00;
            irq_n <= 1'b1;
        end else begin
            flags <= flags_nx;
            irq_n <= ~|(flags_nx & IRQ_MASK);
        end
    end
endmodule

// File: rtl/stream_pkt_buffer.sv
// Top of the banked packet buffer. One song stream uses a private two-bank
// store. Two wave streams share one store of four half-packet banks, and with
// one wave channel wave 1 uses it as two full-size banks. A change of the
// channel count flushes the wave streams.
// Assumes: at most one of song_wr, song_eop, wave1_wr, wave2_wr per cycle.
module stream_pkt_buffer
    import pkt_pkg::*;
#(
    parameter int PKT_BYTES = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] host_wdata,
    input  logic       song_wr,
    input  logic       song_eop,
    input  logic       wave1_wr,
    input  logic       wave2_wr,
    input  logic [1:0] wave_chan,
    input  logic       song_rd,
    output logic       song_rd_valid,
    output logic [7:0] song_rd_data,
    input  logic       wave1_rd,
    output logic       wave1_rd_valid,
    output logic [7:0] wave1_rd_data,
    input  logic       wave2_rd,
    output logic       wave2_rd_valid,
    output logic [7:0] wave2_rd_data,
    input  logic       song_end,
    input  logic       req_rd,
    output logic [7:0] req_data,
    output logic       irq_n
);
    localparam int CW    = $clog2(PKT_BYTES + 1);
    localparam int IW    = $clog2(PKT_BYTES);
    localparam int AW    = IW + 1;
    localparam int HALF  = PKT_BYTES / 2;
    localparam int WORDS = 2 * PKT_BYTES;

    logic [1:0] chan_q;
    logic       flush, w1_on, w2_on, w1_wide;

    logic [N_STREAMS-1:0] s_wr, s_close, s_rd, s_clear, s_auto;
    logic [N_STREAMS-1:0] s_wr_ok, s_drop, s_valid, s_wbank, s_rbank, s_need;
    logic [CW-1:0]        s_len  [N_STREAMS];
    logic [IW-1:0]        s_widx [N_STREAMS];
    logic [IW-1:0]        s_ridx [N_STREAMS];
    logic [7:0]           evt_vec;

    logic [7:0]    song_mem [WORDS];
    logic [7:0]    wave_mem [WORDS];
    logic [AW-1:0] song_waddr, song_raddr;
    logic [AW-1:0] w1_waddr, w1_raddr, w2_waddr, w2_raddr;

    // Physical wave address: full-size banks for one channel, quarters for two.
    function automatic logic [AW-1:0] wave_addr(input logic upper, input logic wide,
                                                input logic bank, input logic [IW-1:0] idx);
        if (wide) return {bank, idx};
        return {upper, bank, idx[IW-2:0]};
    endfunction

    // Registered channel count; any change flushes the wave streams.
    always_ff @(posedge clk) begin
        if (!rst_n) chan_q <= WCH_NONE;
        else        chan_q <= wave_chan;
    end

    // Stream enables and the per-stream control vectors.
    always_comb begin
        flush   = (wave_chan != chan_q);
        w1_on   = (chan_q == WCH_ONE) || (chan_q == WCH_TWO);
        w2_on   = (chan_q == WCH_TWO);
        w1_wide = (chan_q == WCH_ONE);

        s_wr[ST_SONG]     = song_wr;
        s_wr[ST_WAVE1]    = wave1_wr & w1_on;
        s_wr[ST_WAVE2]    = wave2_wr & w2_on;
        s_close[ST_SONG]  = song_eop & (host_wdata != 8'h00);
        s_close[ST_WAVE1] = 1'b0;
        s_close[ST_WAVE2] = 1'b0;
        s_rd[ST_SONG]     = song_rd;
        s_rd[ST_WAVE1]    = wave1_rd;
        s_rd[ST_WAVE2]    = wave2_rd;
        s_clear[ST_SONG]  = 1'b0;
        s_clear[ST_WAVE1] = flush | ~w1_on;
        s_clear[ST_WAVE2] = flush | ~w2_on;
        s_auto[ST_SONG]   = 1'b0;
        s_auto[ST_WAVE1]  = 1'b1;
        s_auto[ST_WAVE2]  = 1'b1;
        s_len[ST_SONG]    = CW'(PKT_BYTES);
        s_len[ST_WAVE1]   = w1_wide ? CW'(PKT_BYTES) : CW'(HALF);
        s_len[ST_WAVE2]   = CW'(HALF);
    end

    // One bank controller per stream.
    for (genvar g = 0; g < N_STREAMS; g++) begin : g_stream
        pkt_bank_ctrl #(.PKT_BYTES(PKT_BYTES)) i_ctrl (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear     (s_clear[g]),
            .pkt_len   (s_len[g]),
            .auto_close(s_auto[g]),
            .wr        (s_wr[g]),
            .close     (s_close[g]),
            .rd        (s_rd[g]),
            .wr_ok     (s_wr_ok[g]),
            .wr_bank   (s_wbank[g]),
            .wr_idx    (s_widx[g]),
            .drop      (s_drop[g]),
            .rd_valid  (s_valid[g]),
            .rd_bank   (s_rbank[g]),
            .rd_idx    (s_ridx[g]),
            .drain_req (s_need[g])
        );
    end

    // Storage address generation for both stores.
    always_comb begin
        song_waddr = {s_wbank[ST_SONG], s_widx[ST_SONG]};
        song_raddr = {s_rbank[ST_SONG], s_ridx[ST_SONG]};
        w1_waddr   = wave_addr(1'b0, w1_wide, s_wbank[ST_WAVE1], s_widx[ST_WAVE1]);
        w1_raddr   = wave_addr(1'b0, w1_wide, s_rbank[ST_WAVE1], s_ridx[ST_WAVE1]);
        w2_waddr   = wave_addr(1'b1, 1'b0, s_wbank[ST_WAVE2], s_widx[ST_WAVE2]);
        w2_raddr   = wave_addr(1'b1, 1'b0, s_rbank[ST_WAVE2], s_ridx[ST_WAVE2]);
    end

    // Byte stores: one write port each, wave 1 before wave 2.
    always_ff @(posedge clk) begin
        if (s_wr_ok[ST_SONG]) song_mem[song_waddr] <= host_wdata;
        if (s_wr_ok[ST_WAVE1])      wave_mem[w1_waddr] <= host_wdata;
        else if (s_wr_ok[ST_WAVE2]) wave_mem[w2_waddr] <= host_wdata;
    end

    assign song_rd_data   = song_mem[song_raddr];
    assign wave1_rd_data  = wave_mem[w1_raddr];
    assign wave2_rd_data  = wave_mem[w2_raddr];
    assign song_rd_valid  = s_valid[ST_SONG];
    assign wave1_rd_valid = s_valid[ST_WAVE1];
    assign wave2_rd_valid = s_valid[ST_WAVE2];

    // Events feeding the request register.
    always_comb begin
        evt_vec           = 8'h00;
        evt_vec[RQ_SONG]  = s_need[ST_SONG];
        evt_vec[RQ_WAVE1] = s_need[ST_WAVE1];
        evt_vec[RQ_WAVE2] = s_need[ST_WAVE2];
        evt_vec[RQ_OVF]   = |s_drop;
        evt_vec[RQ_END]   = song_end;
    end

    pkt_req_reg i_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(evt_vec),
        .rd     (req_rd),
        .flags  (req_data),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/pkt_buffer_checker.sv
// Property checker for the packet buffer, bound to the top module.
module pkt_buffer_checker
    import pkt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       irq_n,
    input logic [7:0] req_data,
    input logic       req_rd,
    input logic       song_end,
    input logic       song_rd,
    input logic       song_rd_valid,
    input logic [7:0] song_rd_data,
    input logic [1:0] wave_chan,
    input logic       wave2_rd_valid,
    input logic       need_song,
    input logic       ovf_evt,
    input logic       irq_evt
);
    AST_SONG_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (song_rd_valid && !song_rd) |=> $stable(song_rd_data)); // R2

    AST_OVF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> req_data[RQ_OVF]); // R3

    AST_WAVE2_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_chan != 2'd2 && $past(wave_chan) != 2'd2) |-> !wave2_rd_valid); // R6

    AST_SONG_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        need_song |=> (!irq_n && req_data[RQ_SONG])); // R7

    AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && !irq_evt) |=> irq_n); // R8

    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rd && song_end) |=> (!irq_n && req_data[RQ_END])); // R9

    AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        song_end |=> (!irq_n && req_data[RQ_END])); // R10
endmodule

bind stream_pkt_buffer pkt_buffer_checker i_pkt_buffer_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_n         (irq_n),
    .req_data      (req_data),
    .req_rd        (req_rd),
    .song_end      (song_end),
    .song_rd       (song_rd),
    .song_rd_valid (song_rd_valid),
    .song_rd_data  (song_rd_data),
    .wave_chan     (wave_chan),
    .wave2_rd_valid(wave2_rd_valid),
    .need_song     (s_need[0]),
    .ovf_evt       (|s_drop),
    .irq_evt       (|(evt_vec & pkt_pkg::IRQ_MASK))
);

// File: tb/test_stream_pkt_buffer.sv
// Directed bench: one task per scenario, each checking its own results.
module test_stream_pkt_buffer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       song_wr = 1'b0, song_eop = 1'b0, wave1_wr = 1'b0, wave2_wr = 1'b0;
    logic [1:0] wave_chan = 2'd0;
    logic       song_rd = 1'b0, wave1_rd = 1'b0, wave2_rd = 1'b0;
    logic       song_end = 1'b0, req_rd = 1'b0;
    logic       song_rd_valid, wave1_rd_valid, wave2_rd_valid, irq_n;
    logic [7:0] song_rd_data, wave1_rd_data, wave2_rd_data, req_data;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stream_pkt_buffer i_stream_pkt_buffer (
        .clk(clk), .rst_n(rst_n), .host_wdata(host_wdata),
        .song_wr(song_wr), .song_eop(song_eop), .wave1_wr(wave1_wr), .wave2_wr(wave2_wr),
        .wave_chan(wave_chan),
        .song_rd(song_rd), .song_rd_valid(song_rd_valid), .song_rd_data(song_rd_data),
        .wave1_rd(wave1_rd), .wave1_rd_valid(wave1_rd_valid), .wave1_rd_data(wave1_rd_data),
        .wave2_rd(wave2_rd), .wave2_rd_valid(wave2_rd_valid), .wave2_rd_data(wave2_rd_data),
        .song_end(song_end), .req_rd(req_rd), .req_data(req_data), .irq_n(irq_n)
    );

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 31 + i * 7 + 3) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_wr(input int s, input logic v);
        song_wr  = (s == 0) ? v : 1'b0;
        wave1_wr = (s == 1) ? v : 1'b0;
        wave2_wr = (s == 2) ? v : 1'b0;
    endtask

    task automatic set_rd(input int s, input logic v);
        song_rd  = (s == 0) ? v : 1'b0;
        wave1_rd = (s == 1) ? v : 1'b0;
        wave2_rd = (s == 2) ? v : 1'b0;
    endtask

    function automatic logic [8:0] rd_port(input int s);
        if (s == 0) return {song_rd_valid, song_rd_data};
        if (s == 1) return {wave1_rd_valid, wave1_rd_data};
        return {wave2_rd_valid, wave2_rd_data};
    endfunction

    task automatic put_bytes(input int s, input int start, input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            set_wr(s, 1'b1);
            host_wdata = pat(seed, start + i);
        end
        @(negedge clk);
        set_wr(s, 1'b0);
    endtask

    task automatic eop(input logic [7:0] v);
        @(negedge clk);
        song_eop = 1'b1;
        host_wdata = v;
        @(negedge clk);
        song_eop = 1'b0;
    endtask

    task automatic drain(input int s, input int start, input int n, input int seed, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            set_rd(s, 1'b1);
            #1;
            if (rd_port(s) != {1'b1, pat(seed, start + i)}) bad++;
        end
        @(negedge clk);
        set_rd(s, 1'b0);
    endtask

    task automatic read_req(output int v);
        @(negedge clk);
        req_rd = 1'b1;
        #1 v = int'(req_data);
        @(negedge clk);
        req_rd = 1'b0;
    endtask

    task automatic set_chan(input logic [1:0] c);
        @(negedge clk);
        wave_chan = c;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 req_data", int'(req_data), 0);
        chk("R1 valids", int'({song_rd_valid, wave1_rd_valid, wave2_rd_valid}), 0);
    endtask

    task automatic t_song;
        int bad, v;
        put_bytes(0, 0, 5, 1);
        eop(8'h00);
        chk("R2 zero eop keeps bank open", int'(song_rd_valid), 0);
        eop(8'h05);
        chk("R2 eop seals bank", int'(song_rd_valid), 1);
        put_bytes(0, 0, 129, 2);
        chk("R3 overflow bit", int'(req_data[3]), 1);
        chk("R3 overflow no irq", int'(irq_n), 1);
        eop(8'h33);
        drain(0, 0, 5, 1, bad);
        chk("R2 first packet order", bad, 0);
        chk("R7 song request irq", int'(irq_n), 0);
        chk("R7 song request bit", int'(req_data[2]), 1);
        read_req(v);
        chk("R8 read value", v, 8'h0C);
        chk("R8 irq released", int'(irq_n), 1);
        chk("R8 flags cleared", int'(req_data), 0);
        drain(0, 0, 128, 2, bad);
        chk("R2 second packet order", bad, 0);
        chk("R7 no request when other empty", int'(irq_n), 1);
        chk("R3 extra byte not stored", int'(song_rd_valid), 0);
    endtask

    task automatic t_wave_one;
        int bad, v;
        set_chan(2'd1);
        put_bytes(1, 0, 127, 3);
        chk("R4 127 bytes not sealed", int'(wave1_rd_valid), 0);
        put_bytes(1, 127, 1, 3);
        chk("R4 128th byte seals", int'(wave1_rd_valid), 1);
        put_bytes(2, 0, 4, 9);
        chk("R4 wave2 ignored", int'(wave2_rd_valid), 0);
        chk("R4 wave2 no overflow", int'(req_data), 0);
        put_bytes(1, 0, 128, 4);
        drain(1, 0, 128, 3, bad);
        chk("R4 wave1 128-byte order", bad, 0);
        chk("R7 wave1 request", int'(req_data), 8'h02);
        chk("R7 wave1 irq", int'(irq_n), 0);
        read_req(v);
        chk("R8 wave1 read value", v, 8'h02);
        drain(1, 0, 128, 4, bad);
        chk("R4 wave1 second bank", bad, 0);
    endtask

    task automatic t_wave_two;
        int bad, v;
        set_chan(2'd2);
        put_bytes(1, 0, 63, 5);
        chk("R5 63 bytes not sealed", int'(wave1_rd_valid), 0);
        put_bytes(1, 63, 1, 5);
        chk("R5 64th byte seals", int'(wave1_rd_valid), 1);
        put_bytes(2, 0, 64, 6);
        put_bytes(2, 0, 64, 7);
        put_bytes(1, 0, 64, 8);
        put_bytes(2, 0, 1, 10);
        read_req(v);
        chk("R3 write into full bank", v, 8'h08);
        drain(2, 0, 64, 6, bad);
        chk("R5 wave2 order", bad, 0);
        chk("R7 wave2 request", int'(req_data), 8'h01);
        drain(1, 0, 63, 5, bad);
        chk("R5 wave1 order", bad, 0);
        @(negedge clk);
        wave1_rd = 1'b1;
        req_rd = 1'b1;
        #1 v = int'(req_data);
        @(negedge clk);
        wave1_rd = 1'b0;
        req_rd = 1'b0;
        chk("R9 read returns earlier flag", v, 8'h01);
        chk("R9 new flag pending", int'(req_data), 8'h02);
        chk("R9 irq held", int'(irq_n), 0);
        read_req(v);
        chk("R8 pending read", v, 8'h02);
        chk("R8 irq released", int'(irq_n), 1);
    endtask

    task automatic t_flush;
        set_chan(2'd1);
        chk("R11 wave1 flushed", int'(wave1_rd_valid), 0);
        chk("R11 wave2 flushed", int'(wave2_rd_valid), 0);
        set_chan(2'd0);
        put_bytes(1, 0, 128, 11);
        chk("R6 wave1 inactive", int'(wave1_rd_valid), 0);
        chk("R6 no flags", int'(req_data), 0);
    endtask

    task automatic t_end;
        int v;
        @(negedge clk);
        song_end = 1'b1;
        @(negedge clk);
        song_end = 1'b0;
        chk("R10 end irq", int'(irq_n), 0);
        chk("R10 end bit", int'(req_data), 8'h20);
        read_req(v);
        chk("R10 end read", v, 8'h20);
        chk("R8 end released", int'(irq_n), 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_song();
        t_wave_one();
        t_wave_two();
        t_flush();
        t_end();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule